// File: doc/BRIEF.md
# Timer Input Edge Detector with Noise Filter

This block conditions an asynchronous timer input and turns a qualified level change into a one-clock pulse. A timer can use that pulse either as its count enable or as the trigger of a capture. The raw input is first brought into the clock domain by a synchronizer chain. A confirmation filter follows, and it accepts a new level only after that level has appeared on consecutive sampling points. In count mode every clock is a sampling point. In capture mode only the clocks where an externally generated prescaler strobe is high are sampling points.

The last accepted level is compared against a stored reference level. The reference resets low and stays frozen while the timer run enable is low. As a result, a level change that happens while the timer is stopped is reported as soon as the timer runs again and the filter has confirmed the new level. A 2-bit code selects which direction counts as a valid edge: falling, rising, both, or none.

Top module: `tin_edge_detect`

## Requirements
- R1: After reset the filtered level and the reference are low and `edge_o` is low, so with the input held low and any edge code no pulse follows once the timer runs.
- R2: `edge_sel_i` encodes 2'b00 = falling only, 2'b01 = rising only, 2'b10 = both directions, 2'b11 = no edge is ever reported.
- R3: In count mode (`capture_mode_i` = 0), a change of `pin_i` that is applied between clock edges and then held is seen as a pulse right after the fourth rising clock edge: two synchronizer stages plus two confirming samples.
- R4: `edge_o` is exactly one clock wide, and each accepted level change gives at most one pulse.
- R5: In count mode, an input level that lasts only one clock is rejected as noise. A level that lasts two clocks is accepted.
- R6: In capture mode (`capture_mode_i` = 1), the filter samples only on clocks where `smp_strobe_i` is high. Once the input is settled, the pulse follows the second strobe sample of the new level and never comes earlier, however long the input has been held.
- R7: While `run_i` is low, `edge_o` stays low and the filtered level, its sample history and the reference all hold their values.
- R8: If the input is high when the timer is first enabled after reset, a rising edge is reported within two enabled clocks when rising or both are selected. It is not reported when falling is selected.
- R9: If the timer stops with the input high and restarts after the input has gone low, a falling edge is reported within two enabled clocks.
- R10: If the timer stops with the input low and restarts after the input has gone high, a rising edge is reported within two enabled clocks.
- R11: With code 2'b11 the reference still follows the filtered level, so switching to another code later reports no stale edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Timer run enable; low freezes filter and reference |
| pin_i | input | 1 | Raw asynchronous timer input |
| edge_sel_i | input | 2 | Valid edge code (see R2) |
| capture_mode_i | input | 1 | 0 = count mode (sample every clock), 1 = capture mode (sample on strobe) |
| smp_strobe_i | input | 1 | Prescaler sampling strobe used in capture mode |
| edge_o | output | 1 | One-clock valid-edge pulse |

## Verification
Every edge code is swept against both rising and falling input steps. This separates the decode of each code and pins down the four-clock latency and the one-clock width. One-clock and two-clock input pulses test the noise threshold. In capture mode the strobe is withheld and then issued one at a time, which shows that only strobe clocks count as samples. Stop and restart sequences change the input while the timer is halted: first enable after reset, stop high then restart low, and stop low then restart high. These sequences tell a frozen reference apart from one that keeps tracking, and they show whether the sample history survives the halt.

// File: rtl/tin_pkg.sv
package tin_pkg;

    typedef enum logic [1:0] {
        SEL_FALL = 2'b00,
        SEL_RISE = 2'b01,
        SEL_BOTH = 2'b10,
        SEL_NONE = 2'b11
    } edge_sel_e;

    typedef enum logic {
        MODE_COUNT   = 1'b0,
        MODE_CAPTURE = 1'b1
    } smp_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic edge_ev_t level_change(input logic prev, input logic now);
        edge_ev_t ev;
        ev.rise = !prev && now;
        ev.fall = prev && !now;
        return ev;
    endfunction

    function automatic logic edge_accept(input edge_sel_e sel, input edge_ev_t ev);
        logic hit;
        unique case (sel)
            SEL_FALL: hit = ev.fall;
            SEL_RISE: hit = ev.rise;
            SEL_BOTH: hit = ev.rise || ev.fall;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tin_sync.sv
module tin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tin_filter.sv
module tin_filter
    import tin_pkg::*;
#(
    parameter int CONFIRM = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    input  smp_mode_e mode_i,
    input  logic      strobe_i,
    input  logic      d_i,
    output logic      level_o
);
    logic               samp_en;
    logic [CONFIRM-1:0] hist;
    logic [CONFIRM-1:0] hist_nx;

    assign samp_en = run_i && ((mode_i == MODE_COUNT) || strobe_i);

    always_comb begin
        hist_nx[0] = d_i;
        for (int i = 1; i < CONFIRM; i++) begin
            hist_nx[i] = hist[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= '0;
            level_o <= 1'b0;
        end else if (samp_en) begin
            hist <= hist_nx;
            if (&hist_nx)       level_o <= 1'b1;
            else if (~|hist_nx) level_o <= 1'b0;
        end
    end

    // R6 / R7: the accepted level moves only on a sampling clock
    p_level_on_sample_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_o) |-> $past(samp_en));

    // R5: a rise is accepted only when the newest sample is high
    p_rise_confirmed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |-> $past(d_i));

    // R5: a fall is accepted only when the newest sample is low
    p_fall_confirmed_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(level_o) |-> !$past(d_i));
endmodule

// File: rtl/tin_ref.sv
module tin_ref
    import tin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    input  edge_sel_e sel_i,
    input  logic      level_i,
    output logic      edge_o
);
    logic     ref_q;
    edge_ev_t ev;

    assign ev     = level_change(ref_q, level_i);
    assign edge_o = run_i && edge_accept(sel_i, ev);

    always_ff @(posedge clk) begin
        if (rst)        ref_q <= 1'b0;
        else if (run_i) ref_q <= level_i;
    end

    // R7: the reference is frozen while stopped
    p_ref_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(ref_q));

    // R4: never two pulses back to back
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

    // R11: after any pulse the reference agrees with the accepted level
    p_ref_follows_r11: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> (ref_q == $past(level_i)));
endmodule

// File: rtl/tin_edge_detect.sv
module tin_edge_detect
    import tin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CONFIRM     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    input  logic       capture_mode_i,
    input  logic       smp_strobe_i,
    output logic       edge_o
);
    logic      pin_sync;
    logic      level;
    edge_sel_e sel;
    smp_mode_e mode;

    assign sel  = edge_sel_e'(edge_sel_i);
    assign mode = smp_mode_e'(capture_mode_i);

    tin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    tin_filter #(.CONFIRM(CONFIRM)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run_i),
        .mode_i   (mode),
        .strobe_i (smp_strobe_i),
        .d_i      (pin_sync),
        .level_o  (level)
    );

    tin_ref u_ref (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_i),
        .sel_i   (sel),
        .level_i (level),
        .edge_o  (edge_o)
    );

    // R7: no pulse while stopped
    p_quiet_stopped_r7: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !edge_o);

    // R2: code 2'b11 never reports
    p_none_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (edge_sel_i == 2'b11) |-> !edge_o);
endmodule

// File: tb/test_tin_edge_detect.sv
module test_tin_edge_detect;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_i = 1'b0;
    logic       pin_i = 1'b0;
    logic [1:0] edge_sel_i = 2'b10;
    logic       capture_mode_i = 1'b0;
    logic       smp_strobe_i = 1'b0;
    logic       edge_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tin_edge_detect i_tin_edge_detect (
        .clk            (clk),
        .rst            (rst),
        .run_i          (run_i),
        .pin_i          (pin_i),
        .edge_sel_i     (edge_sel_i),
        .capture_mode_i (capture_mode_i),
        .smp_strobe_i   (smp_strobe_i),
        .edge_o         (edge_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic watch(input int n, output int cnt, output int first);
        cnt = 0;
        first = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (edge_o) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic do_reset(input logic pin_lvl, input logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1; run_i = 1'b0; pin_i = pin_lvl; edge_sel_i = sel;
        capture_mode_i = 1'b0; smp_strobe_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int wants(input logic [1:0] sel, input logic rising);
        if (sel == 2'b10) return 1;
        if (sel == 2'b01) return rising ? 1 : 0;
        if (sel == 2'b00) return rising ? 0 : 1;
        return 0;
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt, first;

        // R1: reset state
        do_reset(1'b0, 2'b10);
        check("R1 edge low after reset", edge_o, 0);
        run_i = 1'b1;
        watch(8, cnt, first);
        check("R1 no pulse with input low", cnt, 0);

        // R2 R3 R4: sweep codes and directions in count mode
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 2; d++) begin
                edge_sel_i = 2'(s);
                pin_i = (d == 1) ? 1'b0 : 1'b1;
                watch(8, cnt, first);
                pin_i = (d == 1) ? 1'b1 : 1'b0;
                watch(8, cnt, first);
                check($sformatf("R2 count sel=%0d rising=%0d", s, d), cnt, wants(2'(s), d[0]));
                if (wants(2'(s), d[0]) == 1)
                    check($sformatf("R3 latency sel=%0d rising=%0d", s, d), first, 4);
            end
        end

        // R4: pulse exactly one cycle
        edge_sel_i = 2'b10; pin_i = 1'b0;
        watch(8, cnt, first);
        pin_i = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        @(posedge clk); @(negedge clk);
        check("R4 pulse present", edge_o, 1);
        @(posedge clk); @(negedge clk);
        check("R4 pulse gone next cycle", edge_o, 0);
        watch(6, cnt, first);
        check("R4 single pulse", cnt, 0);

        // R5: one-clock glitch rejected, two-clock pulse accepted
        pin_i = 1'b0;
        watch(8, cnt, first);
        pin_i = 1'b1;
        @(negedge clk);
        pin_i = 1'b0;
        watch(10, cnt, first);
        check("R5 one-clock glitch rejected", cnt, 0);
        pin_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pin_i = 1'b0;
        watch(10, cnt, first);
        check("R5 two-clock pulse accepted", cnt, 2);

        // R6: capture mode samples only on strobe
        capture_mode_i = 1'b1;
        pin_i = 1'b1;
        watch(12, cnt, first);
        check("R6 no strobe no pulse", cnt, 0);
        smp_strobe_i = 1'b1;
        @(posedge clk); @(negedge clk);
        smp_strobe_i = 1'b0;
        check("R6 one strobe not enough", edge_o, 0);
        watch(4, cnt, first);
        check("R6 no pulse between strobes", cnt, 0);
        smp_strobe_i = 1'b1;
        @(posedge clk); @(negedge clk);
        smp_strobe_i = 1'b0;
        check("R6 pulse after second strobe", edge_o, 1);
        watch(6, cnt, first);
        check("R6 no further pulse", cnt, 0);
        capture_mode_i = 1'b0;

        // R11: code none keeps tracking
        edge_sel_i = 2'b11;
        pin_i = 1'b0;
        watch(8, cnt, first);
        check("R11 none code silent", cnt, 0);
        edge_sel_i = 2'b00;
        watch(8, cnt, first);
        check("R11 no stale falling edge", cnt, 0);

        // R8 + R7: first enable with input high
        do_reset(1'b1, 2'b01);
        watch(8, cnt, first);
        check("R7 stopped after reset no pulse", cnt, 0);
        run_i = 1'b1;
        watch(6, cnt, first);
        check("R8 rising on first enable", cnt, 1);
        check("R8 within two enabled clocks", first, 2);

        // R9: stop high, restart low
        edge_sel_i = 2'b00;
        run_i = 1'b0;
        pin_i = 1'b0;
        smp_strobe_i = 1'b1;
        watch(8, cnt, first);
        check("R7 stopped input fall ignored", cnt, 0);
        smp_strobe_i = 1'b0;
        run_i = 1'b1;
        watch(6, cnt, first);
        check("R9 falling on restart", cnt, 1);
        check("R9 within two enabled clocks", first, 2);

        // R10: stop low, restart high
        run_i = 1'b0;
        pin_i = 1'b1;
        watch(8, cnt, first);
        check("R7 stopped input rise ignored", cnt, 0);
        edge_sel_i = 2'b01;
        run_i = 1'b1;
        watch(6, cnt, first);
        check("R10 rising on restart", cnt, 1);
        check("R10 within two enabled clocks", first, 2);

        // R8: falling code does not report first-enable rise
        do_reset(1'b1, 2'b00);
        watch(4, cnt, first);
        run_i = 1'b1;
        watch(6, cnt, first);
        check("R8 falling code ignores rise", cnt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule